// File: doc/BRIEF.md
# Serial Infrared Pulse Encoder/Decoder

This block sits between a UART's serial bit lines and an optical infrared transceiver. When the infrared path is active, every zero bit on the UART transmit line becomes one short light pulse. A one bit sends no light. The pulse width comes from one of two sources. In fraction mode it is three sixteen-times-baud ticks, which is 3/16 of a bit period. In low-power mode it is three periods of a separate low-power reference tick, so it does not depend on the baud rate. On the receive side, light pulses from the transceiver are qualified against the low-power tick and stretched back into UART zero bits.

When the infrared path is inactive, the plain UART transmit and receive lines and the modem status lines pass straight through. The infrared output then stays dark. The path is inactive when the infrared enable is 0, or when the UART enable is 0, whatever the infrared enable says. A test loopback can feed the transmitted light pulses back into the receive path, so the UART receives what it sends without an external transceiver. The interfaces are single-bit lines, sampled once per clock. A bit line cannot be stalled, so there is no valid/ready handshake and no back-pressure. Every bit line reads as a level on every clock cycle.

Top module: `sir_endec`

## Requirements
- R1: In fraction mode (`lowpower_i`=0), a zero bit sends exactly one pulse on `ir_pulse_o` (1 = light, 0 = dark). The pulse lasts exactly 3 periods of `tick16_i`, provided the transmit bit changes in a cycle where `tick16_i` is 1. A run of zero bits gives one pulse per bit, every 16 ticks.
- R2: In low-power mode (`lowpower_i`=1), a zero bit sends exactly one pulse of exactly 3 periods of `lp_tick_i`, at any `tick16_i` rate.
- R3: A one bit sends no pulse; `ir_pulse_o` stays 0 for the whole bit.
- R4: With `sir_en_i`=0, `ir_pulse_o` is 0. `ir_rx_n_i` has no effect. `uart_txd_o` follows `tx_bit_i`, `rx_bit_o` follows `uart_rxd_i`, and `modem_sts_o` follows `modem_i`.
- R5: With both `uart_en_i` and `sir_en_i` at 1, `uart_txd_o` is held at 1 (marking). `uart_rxd_i` and `modem_i` have no effect, `modem_sts_o` is 0, and `rx_bit_o` comes from the infrared decoder.
- R6: With `uart_en_i`=0, setting `sir_en_i` changes nothing: the block behaves as in R4.
- R7: With `loop_en_i` and `sir_test_i` both at 1, the decoder input is the inverted infrared output (light on output = light on input), and `ir_rx_n_i` is ignored.
- R8: `ir_rx_n_i` is active low (0 = light). Once a light pulse is accepted, `rx_bit_o` goes to 0 for 16 periods of `tick16_i` and then returns to 1. A received byte therefore reads back correctly at mid-bit.
- R9: A light pulse shorter than one `lp_tick_i` period is rejected and leaves `rx_bit_o` at 1.
- R10: After reset, with the infrared path active and no light, `ir_pulse_o` is 0, `rx_bit_o` is 1 and `uart_txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle strobe at 16x the baud rate |
| lp_tick_i | input | 1 | One-cycle strobe of the low-power reference |
| uart_en_i | input | 1 | UART enable; gates the infrared enable |
| sir_en_i | input | 1 | Infrared path enable |
| lowpower_i | input | 1 | 0 = fraction pulse width, 1 = low-power pulse width |
| loop_en_i | input | 1 | Loopback enable |
| sir_test_i | input | 1 | Infrared test mode; with loop_en_i closes the optical loop |
| tx_bit_i | input | 1 | UART transmit bit stream |
| uart_txd_o | output | 1 | Plain UART transmit line |
| ir_pulse_o | output | 1 | Infrared drive, 1 = light |
| ir_rx_n_i | input | 1 | Infrared receive line, 0 = light |
| uart_rxd_i | input | 1 | Plain UART receive line |
| modem_i | input | MODEM_W | Modem status inputs |
| modem_sts_o | output | MODEM_W | Modem status seen by the UART |
| rx_bit_o | output | 1 | Recovered receive bit stream to the UART |

## Verification
The test drives each change of the transmit bit in the same clock cycle as a 16x tick. The encoder must then decide between two actions: resynchronising the bit phase on the edge, or advancing the phase on the tick. The bit-start load must win, and the pulse width is measured in clock cycles against exactly three tick periods. The same collision occurs in low-power mode, where a bit start can meet a low-power tick. The pulse must still begin on the following tick and last exactly three tick periods. Each case is judged from the measured width and from the byte recovered at mid-bit through the loopback.

// File: rtl/sir_pkg.sv
package sir_pkg;

  typedef enum logic {
    PW_FRACTION = 1'b0,
    PW_LOWPOWER = 1'b1
  } pw_mode_e;

  function automatic int unsigned cnt_bits(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/sir_bit_timer.sv
module sir_bit_timer #(
  parameter int unsigned OS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic bit_i,
  output logic bstart_o
);
  localparam int unsigned PW = sir_pkg::cnt_bits(OS - 1);
  localparam logic [PW-1:0] LAST = PW'(OS - 1);

  logic [PW-1:0] phase_q;
  logic          prev_q;
  logic          edge_w;
  logic          wrap_w;

  assign edge_w   = bit_i != prev_q;
  assign wrap_w   = tick_i && (phase_q == LAST);
  assign bstart_o = !clr_i && (edge_w || wrap_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      prev_q  <= 1'b1;
    end else begin
      prev_q <= bit_i;
      if (clr_i || edge_w) begin
        phase_q <= '0;
      end else if (tick_i) begin
        phase_q <= wrap_w ? '0 : phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sir_encoder.sv
module sir_encoder #(
  parameter int unsigned FRAC_TICKS = 3,
  parameter int unsigned LP_TICKS   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  sir_pkg::pw_mode_e mode_i,
  input  logic              tick_i,
  input  logic              lp_tick_i,
  input  logic              bstart_i,
  input  logic              bit_i,
  output logic              pulse_o
);
  localparam int unsigned MAXW = (FRAC_TICKS > LP_TICKS) ? FRAC_TICKS : LP_TICKS;
  localparam int unsigned CW   = sir_pkg::cnt_bits(MAXW);
  localparam logic [CW-1:0] FRAC_LOAD = CW'(FRAC_TICKS);
  localparam logic [CW-1:0] LP_LOAD   = CW'(LP_TICKS);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (bstart_i && !bit_i) begin
      // fraction mode starts now; low-power waits for its next tick
      if (mode_i == sir_pkg::PW_FRACTION) begin
        cnt_q <= FRAC_LOAD;
      end else begin
        armed_q <= 1'b1;
      end
    end else if (mode_i == sir_pkg::PW_FRACTION) begin
      armed_q <= 1'b0;
      if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end else if (lp_tick_i) begin
      if (armed_q) begin
        cnt_q   <= LP_LOAD;
        armed_q <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pulse_o = cnt_q != '0;
endmodule

// File: rtl/sir_glitch_filter.sv
module sir_glitch_filter #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lp_tick_i,
  input  logic rx_n_i,
  output logic fire_o
);
  logic [SYNC-1:0] sync_q;
  logic            light_w;
  logic            cont_q;
  logic            fired_q;

  for (genvar s = 0; s < SYNC; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q[s] <= 1'b1;
      end else begin
        sync_q[s] <= (s == 0) ? rx_n_i : sync_q[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign light_w = !sync_q[SYNC-1];
  // accepted only when light spans two successive reference ticks
  assign fire_o  = !clr_i && lp_tick_i && light_w && cont_q && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q  <= 1'b0;
      fired_q <= 1'b0;
    end else if (clr_i || !light_w) begin
      cont_q  <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      if (lp_tick_i) cont_q  <= 1'b1;
      if (fire_o)    fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sir_rx_stretch.sv
module sir_rx_stretch #(
  parameter int unsigned OS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic fire_i,
  output logic zero_o
);
  localparam int unsigned HW = sir_pkg::cnt_bits(OS);
  localparam logic [HW-1:0] HOLD = HW'(OS);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (clr_i) begin
      hold_q <= '0;
    end else if (fire_i) begin
      hold_q <= HOLD;
    end else if (tick_i && hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign zero_o = hold_q != '0;
endmodule

// File: rtl/sir_endec.sv
module sir_endec #(
  parameter int unsigned OS         = 16,
  parameter int unsigned FRAC_TICKS = 3,
  parameter int unsigned LP_TICKS   = 3,
  parameter int unsigned SYNC       = 2,
  parameter int unsigned MODEM_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick16_i,
  input  logic               lp_tick_i,
  input  logic               uart_en_i,
  input  logic               sir_en_i,
  input  logic               lowpower_i,
  input  logic               loop_en_i,
  input  logic               sir_test_i,
  input  logic               tx_bit_i,
  output logic               uart_txd_o,
  output logic               ir_pulse_o,
  input  logic               ir_rx_n_i,
  input  logic               uart_rxd_i,
  input  logic [MODEM_W-1:0] modem_i,
  output logic [MODEM_W-1:0] modem_sts_o,
  output logic               rx_bit_o
);
  import sir_pkg::*;

  logic     sir_on;
  logic     clr;
  logic     loop_ir;
  pw_mode_e pw_mode;
  logic     bstart;
  logic     enc_pulse;
  logic     dec_in_n;
  logic     fire;
  logic     rx_zero;

  assign sir_on  = uart_en_i & sir_en_i;
  assign clr     = !sir_on;
  assign loop_ir = loop_en_i & sir_test_i;
  assign pw_mode = pw_mode_e'(lowpower_i);

  sir_bit_timer #(.OS(OS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (tick16_i),
    .bit_i   (tx_bit_i),
    .bstart_o(bstart)
  );

  sir_encoder #(.FRAC_TICKS(FRAC_TICKS), .LP_TICKS(LP_TICKS)) u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .mode_i   (pw_mode),
    .tick_i   (tick16_i),
    .lp_tick_i(lp_tick_i),
    .bstart_i (bstart),
    .bit_i    (tx_bit_i),
    .pulse_o  (enc_pulse)
  );

  // loopback: drive level inverted onto the active-low receive path
  assign dec_in_n = loop_ir ? ~enc_pulse : ir_rx_n_i;

  sir_glitch_filter #(.SYNC(SYNC)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .lp_tick_i(lp_tick_i),
    .rx_n_i   (dec_in_n),
    .fire_o   (fire)
  );

  sir_rx_stretch #(.OS(OS)) u_stretch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .tick_i(tick16_i),
    .fire_i(fire),
    .zero_o(rx_zero)
  );

  assign ir_pulse_o  = sir_on & enc_pulse;
  assign uart_txd_o  = sir_on ? 1'b1 : tx_bit_i;
  assign rx_bit_o    = sir_on ? ~rx_zero : uart_rxd_i;
  assign modem_sts_o = sir_on ? '0 : modem_i;
endmodule

// File: rtl/sir_endec_chk.sv
module sir_endec_chk #(
  parameter int unsigned MODEM_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               uart_en_i,
  input logic               sir_en_i,
  input logic               tx_bit_i,
  input logic               uart_txd_o,
  input logic               ir_pulse_o,
  input logic               uart_rxd_i,
  input logic [MODEM_W-1:0] modem_i,
  input logic [MODEM_W-1:0] modem_sts_o,
  input logic               rx_bit_o
);
  a_r3_rise_needs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ir_pulse_o) |-> !$past(tx_bit_i));

  a_r4_dark_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sir_en_i |-> !ir_pulse_o && (uart_txd_o == tx_bit_i) && (modem_sts_o == modem_i));

  a_r5_txd_marking: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_en_i && sir_en_i) |-> uart_txd_o);

  a_r5_modem_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_en_i && sir_en_i) |-> (modem_sts_o == '0));

  a_r6_uart_off_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uart_en_i |-> !ir_pulse_o && (rx_bit_o == uart_rxd_i) && (uart_txd_o == tx_bit_i));
endmodule

bind sir_endec sir_endec_chk #(.MODEM_W(MODEM_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .uart_en_i  (uart_en_i),
  .sir_en_i   (sir_en_i),
  .tx_bit_i   (tx_bit_i),
  .uart_txd_o (uart_txd_o),
  .ir_pulse_o (ir_pulse_o),
  .uart_rxd_i (uart_rxd_i),
  .modem_i    (modem_i),
  .modem_sts_o(modem_sts_o),
  .rx_bit_o   (rx_bit_o)
);

// File: tb/sim_sir_endec.sv
module sim_sir_endec;
  localparam int OS    = 16;
  localparam int LPDIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int ncyc = 0;
  int tdiv16 = 4;
  logic tick16, lp_tick;
  assign tick16  = (ncyc % tdiv16) == 0;
  assign lp_tick = (ncyc % LPDIV) == 0;

  logic uart_en = 1, sir_en = 1, lowpower = 0, loop_en = 0, sir_test = 0;
  logic tx_bit = 1, ir_rx_n = 1, uart_rxd = 1;
  logic [3:0] modem = 4'h0;
  logic uart_txd, ir_pulse, rx_bit;
  logic [3:0] modem_sts;

  sir_endec u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick16), .lp_tick_i(lp_tick),
    .uart_en_i(uart_en), .sir_en_i(sir_en), .lowpower_i(lowpower),
    .loop_en_i(loop_en), .sir_test_i(sir_test), .tx_bit_i(tx_bit),
    .uart_txd_o(uart_txd), .ir_pulse_o(ir_pulse), .ir_rx_n_i(ir_rx_n),
    .uart_rxd_i(uart_rxd), .modem_i(modem), .modem_sts_o(modem_sts),
    .rx_bit_o(rx_bit)
  );

  int checks = 0;
  int errors = 0;

  // {tick divider, low-power, byte}
  localparam logic [12:0] VEC [0:6] = '{
    {4'd4, 1'b0, 8'h55}, {4'd4, 1'b0, 8'h00}, {4'd4, 1'b0, 8'hFF},
    {4'd4, 1'b1, 8'hA3}, {4'd4, 1'b1, 8'h0F}, {4'd8, 1'b0, 8'h96},
    {4'd8, 1'b1, 8'h3C}
  };

  initial forever begin
    @(negedge clk);
    ncyc++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic align();
    step();
    while ((ncyc % tdiv16) != 0) step();
  endtask

  // drives one bit and observes it for one bit period; assumes tick alignment
  task automatic send_bit(input logic b, input logic lp, input string req);
    int n;
    int hi;
    int rises;
    logic prev;
    logic mid;
    n = OS * tdiv16;
    hi = 0;
    rises = 0;
    prev = 0;
    mid = 1;
    tx_bit = b;
    for (int i = 1; i <= n; i++) begin
      step();
      if (ir_pulse) hi++;
      if (ir_pulse && !prev) rises++;
      prev = ir_pulse;
      if (i == n / 2) mid = rx_bit;
    end
    if (b) begin
      check(rises == 0 && hi == 0, "R3 no light on one bit", hi, 0);
    end else begin
      check(rises == 1, {req, " pulse count"}, rises, 1);
      if (lp) check(hi == 3 * LPDIV, "R2 low-power width", hi, 3 * LPDIV);
      else    check(hi == 3 * tdiv16, "R1 fraction width", hi, 3 * tdiv16);
    end
    check(mid == b, "R8 recovered bit at mid-bit", int'(mid), int'(b));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int lows;
    repeat (4) step();
    rst_n = 1;
    repeat (4) step();
    // R10 reset state
    check(ir_pulse == 0, "R10 dark after reset", int'(ir_pulse), 0);
    check(rx_bit == 1, "R10 rx idle after reset", int'(rx_bit), 1);
    check(uart_txd == 1, "R10 txd marking after reset", int'(uart_txd), 1);

    // R7 loopback vectors, external pin held at light to prove it is ignored
    loop_en = 1;
    sir_test = 1;
    ir_rx_n = 0;
    for (int v = 0; v < 7; v++) begin
      tdiv16 = int'(VEC[v][12:9]);
      lowpower = VEC[v][8];
      repeat (40) step();
      align();
      for (int k = 0; k < 8; k++) send_bit(VEC[v][k], VEC[v][8], "R1/R2 R7 loop");
      tx_bit = 1;
    end
    tdiv16 = 4;
    lowpower = 0;
    loop_en = 0;
    sir_test = 0;
    ir_rx_n = 1;
    repeat (80) step();

    // R5: plain lines ignored while infrared is active
    uart_rxd = 0;
    modem = 4'hF;
    tx_bit = 0;
    repeat (3) step();
    check(rx_bit == 1, "R5 uart_rxd ignored", int'(rx_bit), 1);
    check(modem_sts == 4'h0, "R5 modem masked", int'(modem_sts), 0);
    check(uart_txd == 1, "R5 txd marking", int'(uart_txd), 1);
    tx_bit = 1;
    uart_rxd = 1;
    repeat (80) step();

    // R9: short glitch rejected, then a long pulse accepted
    ir_rx_n = 0;
    repeat (2) step();
    ir_rx_n = 1;
    lows = 0;
    for (int i = 0; i < 80; i++) begin
      step();
      if (!rx_bit) lows++;
    end
    check(lows == 0, "R9 glitch rejected", lows, 0);
    ir_rx_n = 0;
    repeat (10) step();
    ir_rx_n = 1;
    repeat (20) step();
    check(rx_bit == 0, "R8 long pulse gives zero", int'(rx_bit), 0);
    repeat (90) step();
    check(rx_bit == 1, "R8 zero ends after bit period", int'(rx_bit), 1);

    // R4: infrared disabled
    sir_en = 0;
    modem = 4'hA;
    ir_rx_n = 0;
    tx_bit = 0;
    lows = 0;
    for (int i = 0; i < 70; i++) begin
      step();
      if (ir_pulse) lows++;
    end
    check(lows == 0, "R4 dark when disabled", lows, 0);
    check(uart_txd == 0, "R4 txd follows tx", int'(uart_txd), 0);
    check(rx_bit == 1, "R4 ir input ignored", int'(rx_bit), 1);
    check(modem_sts == 4'hA, "R4 modem passes", int'(modem_sts), 10);
    uart_rxd = 0;
    step();
    check(rx_bit == 0, "R4 rx follows uart_rxd", int'(rx_bit), 0);

    // R6: infrared enable without UART enable
    uart_en = 0;
    sir_en = 1;
    uart_rxd = 1;
    tx_bit = 1;
    step();
    tx_bit = 0;
    lows = 0;
    for (int i = 0; i < 70; i++) begin
      step();
      if (ir_pulse) lows++;
    end
    check(lows == 0, "R6 dark with uart off", lows, 0);
    check(uart_txd == 0, "R6 txd follows tx", int'(uart_txd), 0);
    check(rx_bit == 1, "R6 rx follows uart_rxd", int'(rx_bit), 1);
    check(modem_sts == 4'hA, "R6 modem passes", int'(modem_sts), 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule